// File: doc/BRIEF.md
# Peak-Driven Receive Gain Loop

This block is the slow automatic gain loop for one receive channel. It keeps an 8-bit gain index and adjusts it from peak-threshold events reported by two detectors. One is an analog-style peak detector and the other is an overload detector on decimated data. Each detector has an upper-threshold strobe and a lower-threshold strobe. The loop counts these strobes over a programmable update interval. At the end of the interval it either lowers the gain by an attack step, raises it by a recovery step, or leaves it unchanged.

Measurement is paused in two cases. The first is a settling hold-off after every gain change, which lets transients die away. The second is an entry delay, counted in microseconds, after the receive enable rises. A two-bit per-detector enable lets an excess of upper-threshold events cut the gain at once instead of at the interval end. Two further options exist. One returns the gain to maximum while receive is off. The other forbids any increase while upper-threshold events are still being seen. The parameter `CYC_PER_US` sets how many clock cycles make one microsecond.

Top module: `agc_pk_loop`

## Requirements
- R1: After reset `gain_idx` is `GAIN_RST` (255) and `gain_chg` is 0. Every value reached by a gain change lies within [`cfg_gain_min`, `cfg_gain_max`].
- R2: At an interval end, the gain drops by `cfg_atk_step` if either of these holds: the peak detector's upper count is strictly greater than `cfg_pk_hi_cnt`, or the overload detector's upper count is strictly greater than `cfg_ov_hi_cnt`. The result is clamped at `cfg_gain_min`.
- R3: At an interval end with no attack, the gain rises by `cfg_rcv_step` when both lower counts are strictly below their limits (`cfg_pk_lo_cnt`, `cfg_ov_lo_cnt`). The result is clamped at `cfg_gain_max`.
- R4: When the attack and recovery conditions both hold in the same interval, the attack is applied.
- R5: An interval spans `cfg_ivl_cyc`+1 active cycles. A strobe in the last cycle counts toward that interval's decision. All event counts restart at each interval end, at each gain decision and while the loop is inactive.
- R6: `gain_chg` is a one-cycle pulse, issued in the cycle after the decision edge, and only when the index value actually changed. A decision that is clamped to the current value gives no pulse.
- R7: After a gain change the loop ignores strobes for `cfg_settle_cyc` cycles. The interval count restarts once measurement resumes.
- R8: After `rx_en` rises, the loop stays inactive for `cfg_entry_us` × `CYC_PER_US` cycles.
- R9: `cfg_fast_atk` bit 0 (peak detector) and bit 1 (overload detector) each enable an immediate attack. The attack fires in the cycle where that detector's upper count, including the current strobe, first exceeds its limit. A clear bit leaves that detector to the interval end.
- R10: While `rx_en` is low, the gain holds its value when `cfg_max_on_off` is 0, and becomes `cfg_gain_max` one cycle later when `cfg_max_on_off` is 1. Neither case pulses `gain_chg`.
- R11: With `cfg_no_inc_on_peak` set, no recovery occurs in an interval that saw any upper-threshold event from either detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| pk_hi_evt | input | 1 | Peak detector upper-threshold strobe |
| pk_lo_evt | input | 1 | Peak detector lower-threshold strobe |
| ov_hi_evt | input | 1 | Overload detector upper-threshold strobe |
| ov_lo_evt | input | 1 | Overload detector lower-threshold strobe |
| cfg_gain_min | input | GW | Lowest allowed gain index |
| cfg_gain_max | input | GW | Highest allowed gain index, target of return-to-max |
| cfg_pk_hi_cnt | input | CW | Peak upper count limit |
| cfg_pk_lo_cnt | input | CW | Peak lower count limit |
| cfg_ov_hi_cnt | input | CW | Overload upper count limit |
| cfg_ov_lo_cnt | input | CW | Overload lower count limit |
| cfg_atk_step | input | SW | Attack decrement |
| cfg_rcv_step | input | SW | Recovery increment |
| cfg_settle_cyc | input | STW | Hold-off cycles after a change |
| cfg_entry_us | input | EDW | Receive-entry delay in microseconds |
| cfg_ivl_cyc | input | IVW | Interval length minus one, in cycles |
| cfg_fast_atk | input | 2 | Immediate-attack enables (bit 0 peak, bit 1 overload) |
| cfg_max_on_off | input | 1 | Return to maximum gain while receive is off |
| cfg_no_inc_on_peak | input | 1 | Block recovery after any upper event |
| gain_idx | output | GW | Current gain index |
| gain_chg | output | 1 | One-cycle gain-changed pulse |

## Verification
The bench probes each count limit exactly at its boundary: a count equal to the limit must neither attack nor block recovery. An off-by-one comparator would move the gain one interval too early. It runs back-to-back intervals without dropping receive, so that counts leaking across an interval end would trigger a false attack. It also drives attacks and recoveries into both clamps: a wrong clamp would wrap the index, and a wrong strobe rule would pulse `gain_chg` with no change. Finally, it times the immediate attack edge-exact after the entry delay and after the settling hold-off. A design that counted events too early or resumed too late shifts that edge.

// File: rtl/agc_pk_pkg.sv
package agc_pk_pkg;
  localparam int NUM_EV   = 4;
  localparam int EV_PK_HI = 0;
  localparam int EV_PK_LO = 1;
  localparam int EV_OV_HI = 2;
  localparam int EV_OV_LO = 3;

  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_ATTACK  = 2'd1,
    ACT_RECOVER = 2'd2
  } agc_act_e;
endpackage

// File: rtl/agc_pk_evcnt.sv
module agc_pk_evcnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          clr,
  output logic [CW-1:0] cnt_eff
);
  localparam logic [CW-1:0] CNT_TOP = '1;

  logic [CW-1:0] cnt_q, cnt_d;

  // count including the strobe of this cycle, saturating
  always_comb begin
    cnt_eff = cnt_q;
    if (hit && (cnt_q != CNT_TOP)) cnt_eff = cnt_q + 1'b1;
    cnt_d = clr ? '0 : cnt_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/agc_pk_timing.sv
module agc_pk_timing #(
  parameter int STW        = 7,
  parameter int EDW        = 8,
  parameter int IVW        = 16,
  parameter int CYC_PER_US = 250
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_en,
  input  logic [STW-1:0] cfg_settle_cyc,
  input  logic [EDW-1:0] cfg_entry_us,
  input  logic [IVW-1:0] cfg_ivl_cyc,
  input  logic           settle_load,
  input  logic           ivl_restart,
  output logic           active,
  output logic           boundary
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0]  pre_q, pre_d;
  logic [EDW-1:0] ent_q, ent_d;
  logic [STW-1:0] stl_q, stl_d;
  logic [IVW-1:0] ivl_q, ivl_d;
  logic           entry_done;

  always_comb begin
    entry_done = rx_en && (ent_q >= cfg_entry_us);
    pre_d = pre_q;
    ent_d = ent_q;
    if (!rx_en) begin
      pre_d = '0;
      ent_d = '0;
    end else if (!entry_done) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        ent_d = ent_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end

    if (settle_load)         stl_d = cfg_settle_cyc;
    else if (stl_q != '0)    stl_d = stl_q - 1'b1;
    else                     stl_d = stl_q;

    active   = entry_done && (stl_q == '0);
    boundary = active && (ivl_q == cfg_ivl_cyc);

    if (!active || boundary || ivl_restart) ivl_d = '0;
    else                                    ivl_d = ivl_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ent_q <= '0;
      stl_q <= '0;
      ivl_q <= '0;
    end else begin
      pre_q <= pre_d;
      ent_q <= ent_d;
      stl_q <= stl_d;
      ivl_q <= ivl_d;
    end
  end
endmodule

// File: rtl/agc_pk_decide.sv
module agc_pk_decide
  import agc_pk_pkg::*;
#(
  parameter int GW       = 8,
  parameter int CW       = 8,
  parameter int SW       = 5,
  parameter int GAIN_RST = 255
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_en,
  input  logic                     active,
  input  logic                     boundary,
  input  logic [NUM_EV-1:0][CW-1:0] ev_cnt,
  input  logic [GW-1:0]            cfg_gain_min,
  input  logic [GW-1:0]            cfg_gain_max,
  input  logic [CW-1:0]            cfg_pk_hi_cnt,
  input  logic [CW-1:0]            cfg_pk_lo_cnt,
  input  logic [CW-1:0]            cfg_ov_hi_cnt,
  input  logic [CW-1:0]            cfg_ov_lo_cnt,
  input  logic [SW-1:0]            cfg_atk_step,
  input  logic [SW-1:0]            cfg_rcv_step,
  input  logic [1:0]               cfg_fast_atk,
  input  logic                     cfg_max_on_off,
  input  logic                     cfg_no_inc_on_peak,
  output logic                     fast_hit,
  output logic                     chg_next,
  output logic [GW-1:0]            gain_idx,
  output logic                     gain_chg
);
  localparam int XW = GW + 2;

  logic [GW-1:0] gain_q, gain_d;
  logic          chg_q;
  logic          pk_over, ov_over, all_under, peaked;
  agc_act_e      act;
  logic [XW-1:0] raw;
  logic [GW-1:0] tgt;

  always_comb begin
    pk_over   = ev_cnt[EV_PK_HI] > cfg_pk_hi_cnt;
    ov_over   = ev_cnt[EV_OV_HI] > cfg_ov_hi_cnt;
    all_under = (ev_cnt[EV_PK_LO] < cfg_pk_lo_cnt) && (ev_cnt[EV_OV_LO] < cfg_ov_lo_cnt);
    peaked    = (ev_cnt[EV_PK_HI] != '0) || (ev_cnt[EV_OV_HI] != '0);
    fast_hit  = active && ((cfg_fast_atk[0] && pk_over) || (cfg_fast_atk[1] && ov_over));

    act = ACT_HOLD;
    if (fast_hit || (boundary && (pk_over || ov_over)))
      act = ACT_ATTACK;
    else if (boundary && all_under && !(cfg_no_inc_on_peak && peaked))
      act = ACT_RECOVER;

    // widened arithmetic: MSB flags an underflow of the subtraction
    if (act == ACT_ATTACK) raw = {2'b00, gain_q} - {{(XW-SW){1'b0}}, cfg_atk_step};
    else                   raw = {2'b00, gain_q} + {{(XW-SW){1'b0}}, cfg_rcv_step};

    if (raw[XW-1] || (raw < {2'b00, cfg_gain_min})) tgt = cfg_gain_min;
    else if (raw > {2'b00, cfg_gain_max})          tgt = cfg_gain_max;
    else                                           tgt = raw[GW-1:0];

    gain_d   = gain_q;
    chg_next = 1'b0;
    if (!rx_en) begin
      if (cfg_max_on_off) gain_d = cfg_gain_max;
    end else if (act != ACT_HOLD) begin
      gain_d   = tgt;
      chg_next = (tgt != gain_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GW'(GAIN_RST);
      chg_q  <= 1'b0;
    end else begin
      gain_q <= gain_d;
      chg_q  <= chg_next;
    end
  end

  assign gain_idx = gain_q;
  assign gain_chg = chg_q;
endmodule

// File: rtl/agc_pk_loop.sv
module agc_pk_loop
  import agc_pk_pkg::*;
#(
  parameter int GW         = 8,
  parameter int CW         = 8,
  parameter int SW         = 5,
  parameter int STW        = 7,
  parameter int EDW        = 8,
  parameter int IVW        = 16,
  parameter int CYC_PER_US = 250,
  parameter int GAIN_RST   = 255
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_en,
  input  logic           pk_hi_evt,
  input  logic           pk_lo_evt,
  input  logic           ov_hi_evt,
  input  logic           ov_lo_evt,
  input  logic [GW-1:0]  cfg_gain_min,
  input  logic [GW-1:0]  cfg_gain_max,
  input  logic [CW-1:0]  cfg_pk_hi_cnt,
  input  logic [CW-1:0]  cfg_pk_lo_cnt,
  input  logic [CW-1:0]  cfg_ov_hi_cnt,
  input  logic [CW-1:0]  cfg_ov_lo_cnt,
  input  logic [SW-1:0]  cfg_atk_step,
  input  logic [SW-1:0]  cfg_rcv_step,
  input  logic [STW-1:0] cfg_settle_cyc,
  input  logic [EDW-1:0] cfg_entry_us,
  input  logic [IVW-1:0] cfg_ivl_cyc,
  input  logic [1:0]     cfg_fast_atk,
  input  logic           cfg_max_on_off,
  input  logic           cfg_no_inc_on_peak,
  output logic [GW-1:0]  gain_idx,
  output logic           gain_chg
);
  logic                      active, boundary, fast_hit, chg_next, cnt_clr;
  logic [NUM_EV-1:0]         ev_in;
  logic [NUM_EV-1:0][CW-1:0] ev_cnt;

  always_comb begin
    ev_in[EV_PK_HI] = pk_hi_evt;
    ev_in[EV_PK_LO] = pk_lo_evt;
    ev_in[EV_OV_HI] = ov_hi_evt;
    ev_in[EV_OV_LO] = ov_lo_evt;
    cnt_clr = !active || boundary || fast_hit;
  end

  agc_pk_timing #(
    .STW(STW), .EDW(EDW), .IVW(IVW), .CYC_PER_US(CYC_PER_US)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .cfg_settle_cyc(cfg_settle_cyc), .cfg_entry_us(cfg_entry_us), .cfg_ivl_cyc(cfg_ivl_cyc),
    .settle_load(chg_next), .ivl_restart(fast_hit),
    .active(active), .boundary(boundary)
  );

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    agc_pk_evcnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .hit(ev_in[i] && active), .clr(cnt_clr),
      .cnt_eff(ev_cnt[i])
    );
  end

  agc_pk_decide #(
    .GW(GW), .CW(CW), .SW(SW), .GAIN_RST(GAIN_RST)
  ) u_decide (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .active(active), .boundary(boundary), .ev_cnt(ev_cnt),
    .cfg_gain_min(cfg_gain_min), .cfg_gain_max(cfg_gain_max),
    .cfg_pk_hi_cnt(cfg_pk_hi_cnt), .cfg_pk_lo_cnt(cfg_pk_lo_cnt),
    .cfg_ov_hi_cnt(cfg_ov_hi_cnt), .cfg_ov_lo_cnt(cfg_ov_lo_cnt),
    .cfg_atk_step(cfg_atk_step), .cfg_rcv_step(cfg_rcv_step),
    .cfg_fast_atk(cfg_fast_atk), .cfg_max_on_off(cfg_max_on_off),
    .cfg_no_inc_on_peak(cfg_no_inc_on_peak),
    .fast_hit(fast_hit), .chg_next(chg_next),
    .gain_idx(gain_idx), .gain_chg(gain_chg)
  );
endmodule

// File: rtl/agc_pk_loop_chk.sv
module agc_pk_loop_chk #(
  parameter int GW  = 8,
  parameter int STW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rx_en,
  input logic [GW-1:0]  cfg_gain_min,
  input logic [GW-1:0]  cfg_gain_max,
  input logic [STW-1:0] cfg_settle_cyc,
  input logic           cfg_max_on_off,
  input logic [GW-1:0]  gain_idx,
  input logic           gain_chg
);
  p_gain_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gain_chg |-> (gain_idx >= cfg_gain_min && gain_idx <= cfg_gain_max));

  p_chg_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gain_chg |-> (gain_idx != $past(gain_idx)));

  p_settle_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_chg && cfg_settle_cyc != '0) |=> !gain_chg);

  p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !cfg_max_on_off) |=> ($stable(gain_idx) && !gain_chg));

  p_max_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && cfg_max_on_off) |=> (gain_idx == $past(cfg_gain_max) && !gain_chg));
endmodule

bind agc_pk_loop agc_pk_loop_chk #(.GW(GW), .STW(STW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
  .cfg_gain_min(cfg_gain_min), .cfg_gain_max(cfg_gain_max),
  .cfg_settle_cyc(cfg_settle_cyc), .cfg_max_on_off(cfg_max_on_off),
  .gain_idx(gain_idx), .gain_chg(gain_chg)
);

// File: tb/sim_agc_pk_loop.sv
`timescale 1ns/1ps
module sim_agc_pk_loop;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        pk_hi_evt = 1'b0, pk_lo_evt = 1'b0, ov_hi_evt = 1'b0, ov_lo_evt = 1'b0;
  logic [7:0]  cfg_gain_min = 8'd195, cfg_gain_max = 8'd255;
  logic [7:0]  cfg_pk_hi_cnt = 8'd6, cfg_pk_lo_cnt = 8'd3, cfg_ov_hi_cnt = 8'd6, cfg_ov_lo_cnt = 8'd3;
  logic [4:0]  cfg_atk_step = 5'd4, cfg_rcv_step = 5'd2;
  logic [6:0]  cfg_settle_cyc = 7'd0;
  logic [7:0]  cfg_entry_us = 8'd0;
  logic [15:0] cfg_ivl_cyc = 16'd15;
  logic [1:0]  cfg_fast_atk = 2'b00;
  logic        cfg_max_on_off = 1'b0, cfg_no_inc_on_peak = 1'b0;
  logic [7:0]  gain_idx;
  logic        gain_chg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  agc_pk_loop #(.CYC_PER_US(4)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .pk_hi_evt(pk_hi_evt), .pk_lo_evt(pk_lo_evt), .ov_hi_evt(ov_hi_evt), .ov_lo_evt(ov_lo_evt),
    .cfg_gain_min(cfg_gain_min), .cfg_gain_max(cfg_gain_max),
    .cfg_pk_hi_cnt(cfg_pk_hi_cnt), .cfg_pk_lo_cnt(cfg_pk_lo_cnt),
    .cfg_ov_hi_cnt(cfg_ov_hi_cnt), .cfg_ov_lo_cnt(cfg_ov_lo_cnt),
    .cfg_atk_step(cfg_atk_step), .cfg_rcv_step(cfg_rcv_step),
    .cfg_settle_cyc(cfg_settle_cyc), .cfg_entry_us(cfg_entry_us), .cfg_ivl_cyc(cfg_ivl_cyc),
    .cfg_fast_atk(cfg_fast_atk), .cfg_max_on_off(cfg_max_on_off),
    .cfg_no_inc_on_peak(cfg_no_inc_on_peak),
    .gain_idx(gain_idx), .gain_chg(gain_chg)
  );

  // {peak hi, peak lo, ovl hi, ovl lo event counts, expected gain, expected pulse}
  localparam logic [28:0] VEC [12] = '{
    {5'd7, 5'd5, 5'd0, 5'd5, 8'd251, 1'b1},  // R2 peak attack
    {5'd6, 5'd5, 5'd0, 5'd5, 8'd251, 1'b0},  // R2 count equal to limit: hold
    {5'd0, 5'd5, 5'd7, 5'd5, 8'd247, 1'b1},  // R2 overload attack
    {5'd0, 5'd2, 5'd0, 5'd2, 8'd249, 1'b1},  // R3 recovery
    {5'd0, 5'd2, 5'd0, 5'd3, 8'd249, 1'b0},  // R3 lower count equal: hold
    {5'd0, 5'd0, 5'd0, 5'd0, 8'd251, 1'b1},  // R3
    {5'd7, 5'd0, 5'd0, 5'd0, 8'd247, 1'b1},  // R4 attack wins
    {5'd3, 5'd0, 5'd0, 5'd0, 8'd249, 1'b1},  // R11 off: recovery despite peaks
    {5'd0, 5'd0, 5'd0, 5'd0, 8'd251, 1'b1},
    {5'd0, 5'd1, 5'd0, 5'd1, 8'd253, 1'b1},
    {5'd0, 5'd0, 5'd0, 5'd0, 8'd255, 1'b1},
    {5'd0, 5'd0, 5'd0, 5'd0, 8'd255, 1'b0}   // R6 clamp at max: no pulse
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // one interval of 16 active cycles, starting and ending with receive off
  task automatic run_ivl(input int pu, input int pl, input int ou, input int ol,
                         output int g, output int c);
    for (int j = 0; j < 16; j++) begin
      rx_en = 1'b1;
      pk_hi_evt = (j < pu); pk_lo_evt = (j < pl);
      ov_hi_evt = (j < ou); ov_lo_evt = (j < ol);
      @(negedge clk);
    end
    g = gain_idx; c = gain_chg;
    rx_en = 1'b0;
    pk_hi_evt = 1'b0; pk_lo_evt = 1'b0; ov_hi_evt = 1'b0; ov_lo_evt = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_off();
    rx_en = 1'b0;
    pk_hi_evt = 1'b0; pk_lo_evt = 1'b0; ov_hi_evt = 1'b0; ov_lo_evt = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int g, c, seen, k1, k2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset gain", gain_idx, 255);
    chk("R1 reset pulse", gain_chg, 0);

    foreach (VEC[i]) begin
      run_ivl(VEC[i][28:24], VEC[i][23:19], VEC[i][18:14], VEC[i][13:9], g, c);
      chk($sformatf("R2/R3/R4 vector %0d gain", i), g, VEC[i][8:1]);
      chk($sformatf("R6 vector %0d pulse", i), c, VEC[i][0]);
    end

    // R5: counts restart at each interval end (4+4 upper events must not add up)
    seen = 0;
    for (int j = 0; j < 32; j++) begin
      rx_en = 1'b1;
      pk_hi_evt = ((j % 16) < 4); pk_lo_evt = ((j % 16) < 5); ov_lo_evt = ((j % 16) < 5);
      @(negedge clk);
      if (gain_chg) seen++;
    end
    rx_off();
    chk("R5 no carry across intervals gain", gain_idx, 255);
    chk("R5 no carry across intervals pulses", seen, 0);

    // R2 clamp at minimum, then R6 no pulse when already at minimum
    cfg_gain_min = 8'd250; cfg_atk_step = 5'd31;
    run_ivl(7, 5, 0, 5, g, c);
    chk("R2 clamp at min", g, 250);
    chk("R1 pulse on clamped change", c, 1);
    run_ivl(7, 5, 0, 5, g, c);
    chk("R6 no pulse at min", c, 0);
    cfg_atk_step = 5'd4;

    // R11 recovery blocked by any upper event
    cfg_no_inc_on_peak = 1'b1;
    run_ivl(1, 0, 0, 0, g, c);
    chk("R11 blocked recovery", g, 250);
    run_ivl(0, 0, 0, 0, g, c);
    chk("R11 recovery without peaks", g, 252);
    cfg_no_inc_on_peak = 1'b0; cfg_gain_min = 8'd195;

    // R10 hold while off, then return to maximum
    repeat (4) @(negedge clk);
    chk("R10 hold while off", gain_idx, 252);
    cfg_max_on_off = 1'b1;
    @(negedge clk);
    chk("R10 max while off", gain_idx, 255);
    chk("R10 no pulse", gain_chg, 0);
    cfg_max_on_off = 1'b0;

    // R9 fast attack on overload detector (bit 1): change at 7th strobe edge
    cfg_fast_atk = 2'b10;
    for (int j = 1; j <= 7; j++) begin
      rx_en = 1'b1; ov_hi_evt = 1'b1;
      @(negedge clk);
      if (j == 6) chk("R9 no change before limit", gain_idx, 255);
    end
    chk("R9 fast attack overload", gain_idx, 251);
    chk("R9 fast attack pulse", gain_chg, 1);
    rx_off();

    // R9 bit 0 only: overload excess must wait for interval end
    cfg_fast_atk = 2'b01;
    for (int j = 1; j <= 8; j++) begin
      rx_en = 1'b1; ov_hi_evt = 1'b1;
      @(negedge clk);
    end
    chk("R9 disabled detector waits", gain_idx, 251);
    rx_off();

    // R8 entry delay of 2 us = 8 cycles, then 7 strobes
    cfg_entry_us = 8'd2;
    for (int j = 1; j <= 15; j++) begin
      rx_en = 1'b1; pk_hi_evt = 1'b1;
      @(negedge clk);
      if (j == 14) chk("R8 inactive during entry delay", gain_idx, 251);
    end
    chk("R8 attack after entry delay", gain_idx, 247);
    rx_off();
    cfg_entry_us = 8'd0;

    // R7 settle of 5 cycles: pulses 12 cycles apart, each one cycle wide
    cfg_settle_cyc = 7'd5;
    k1 = 0; k2 = 0;
    for (int k = 1; k <= 25; k++) begin
      rx_en = 1'b1; pk_hi_evt = 1'b1;
      @(negedge clk);
      if (gain_chg && k1 == 0) k1 = k;
      else if (gain_chg && k2 == 0) k2 = k;
      if (k1 != 0 && k == k1 + 1) chk("R6 pulse one cycle wide", gain_chg, 0);
    end
    chk("R9 first fast attack cycle", k1, 7);
    chk("R7 settle hold-off spacing", k2 - k1, 12);
    chk("R7 gain after two attacks", gain_idx, 239);
    rx_off();
    cfg_settle_cyc = 7'd0;

    finish_run();
  end
endmodule